// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the register side of a simple colour LCD controller. It sits on a 4 KB word-addressed bus window and holds four panel timing words, the upper and lower panel frame base addresses, a control word and an interrupt mask. It also tracks raw and masked interrupt status. From these registers it derives the active panel width and height, the pixel depth code and the byte/pixel/colour ordering flags, together with a display enable. A pixel fetch engine and a video timing generator downstream consume these outputs. The window also carries a 128-word palette store and a read-only identification window of eight bytes.

A frame-period counter stands in for the vertical blanking event. While the display is enabled, the counter expires every `FRAME_CYCLES` clock cycles. Each expiry sets the next-base and vertical-compare status bits together. A level interrupt is raised whenever any raw status bit that the mask enables is set. Software acknowledges an event by writing ones to the clear register.

A `VARIANT` parameter selects one of three flavours. Variant 0 places the control word below the mask. Variants 1 and 2 place the mask below the control word. Variant 2 also reports a different identification byte set.

Top module: `lcdc_regif`

## Requirements
- R1: The word index is bus_addr[11:2]. Indices 0 to 3 are the four timing words and index 4 is the upper base, index 5 the lower base; each reads back all 32 written bits. Index 11 returns the upper base and index 12 the lower base, and writes to indices 11 and 12 are ignored.
- R2: With VARIANT 0 the control word (16 bits) is at index 6 and the mask (5 bits) at index 7. With VARIANT 1 or 2 the mask is at index 6 and the control word at index 7. Unused upper bits read as zero.
- R3: Raw status is at index 8, is 5 bits wide and ignores writes. Masked status at index 9 reads raw AND mask. irq is high exactly while that AND is non-zero.
- R4: A write to index 10 clears each raw status bit whose write-data bit is 1 and reads as zero. A frame expiry in the same cycle still sets its bits.
- R5: act_width equals 16 × (timing0[7:2] + 1), so timing0 bits [1:0] have no effect. act_height equals timing1[9:0] + 1.
- R6: disp_en is high only when control bit 0 and control bit 11 are both 1. pix_depth is control[3:1], rgb_swap is control bit 8, be_byte is control bit 9, and be_pix is control bit 10.
- R7: A control write with bits 0 and 11 both set restarts the frame counter. Raw status bits 2 and 3 become set FRAME_CYCLES cycles after that write edge, and again every FRAME_CYCLES cycles while disp_en stays high. No bits are set while disp_en is low.
- R8: Byte offsets 0xFE0 to 0xFFF return one identification byte per word, zero-extended, and ignore writes. For words 0 to 7 the bytes are 10 11 04 00 0D F0 05 B1 (hex) for VARIANT 0 and 1, and 11 11 24 00 0D F0 05 B1 for VARIANT 2.
- R9: Byte offsets 0x200 to 0x3FF form a 128-word palette store. Each word reads back the full 32 bits written.
- R10: Any other offset, including indices 13 to 127, reads as zero and ignores writes. bad_acc is high for exactly the one cycle after such a read or write, and stays low after mapped accesses.
- R11: bus_rdata takes the addressed value at the clock edge where bus_rd is sampled and holds it until the next read. After reset, all registers, bus_rdata, irq, disp_en and bad_acc are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bad_acc | output | 1 | One-cycle flag for an access to an unmapped offset |
| irq | output | 1 | Level interrupt, masked status non-zero |
| disp_en | output | 1 | Display enabled (enable and power bits set) |
| act_width | output | 11 | Decoded active width in pixels |
| act_height | output | 11 | Decoded active height in lines |
| pix_depth | output | 3 | Pixel depth code |
| rgb_swap | output | 1 | Blue/red order select |
| be_byte | output | 1 | Big-endian byte order |
| be_pix | output | 1 | Big-endian pixel order within a byte |
| fb_upper | output | 32 | Upper panel frame base |
| fb_lower | output | 32 | Lower panel frame base |

## Verification
A corrupted register shows up on the decoded outputs in the cycle after the write. It also shows up in bus_rdata one cycle after a read of that index. A frame counter that is off by even one count shifts the rise of irq by one cycle, and the bench measures this exactly from the enabling write and between two expiries. An error in status clearing or masking appears on irq immediately, since irq follows the status and mask registers with no delay. A decode error shows up either as a wrong readback or as a wrong bad_acc pulse in the cycle after the access.

// File: rtl/lcdc_regif_pkg.sv
// Package lcdc_regif_pkg
// Shared constants, the address region type and the identification byte
// table for the LCD controller register unit. Assumes a 32-bit data bus.
package lcdc_regif_pkg;

    localparam int DATA_W       = 32;
    localparam int DIM_W        = 11;
    localparam int TIMING_WORDS = 4;
    localparam int REG_WORDS    = 13;
    localparam int ID_WORDS     = 8;

    // Register word indices that do not depend on the variant
    localparam logic [3:0] IX_UP_BASE = 4'd4;
    localparam logic [3:0] IX_LO_BASE = 4'd5;
    localparam logic [3:0] IX_RAW     = 4'd8;
    localparam logic [3:0] IX_MASKED  = 4'd9;
    localparam logic [3:0] IX_CLEAR   = 4'd10;
    localparam logic [3:0] IX_UP_CUR  = 4'd11;
    localparam logic [3:0] IX_LO_CUR  = 4'd12;

    // Control bit positions
    localparam int CB_ENABLE = 0;
    localparam int CB_SWAP   = 8;
    localparam int CB_BEBYTE = 9;
    localparam int CB_BEPIX  = 10;
    localparam int CB_POWER  = 11;

    // Status bits set by a frame expiry
    localparam int SB_NEXTBASE = 2;
    localparam int SB_VCOMP    = 3;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_REG  = 2'd1,
        RG_PAL  = 2'd2,
        RG_ID   = 2'd3
    } region_t;

    // Identification byte n for the given variant
    function automatic logic [7:0] id_byte(input int variant, input logic [2:0] n);
        case (n)
            3'd0:    return (variant == 2) ? 8'h11 : 8'h10;
            3'd1:    return 8'h11;
            3'd2:    return (variant == 2) ? 8'h24 : 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/lcdc_addr_decode.sv
// Module lcdc_addr_decode
// Splits a word index into register, palette, identification or unmapped
// regions and gives the local index inside each. Purely combinational.
// Assumes the palette and identification windows do not overlap the
// register words.
module lcdc_addr_decode
    import lcdc_regif_pkg::*;
#(
    parameter int IDX_W     = 10,
    parameter int PAL_BASE  = 128,
    parameter int PAL_WORDS = 128,
    localparam int PAL_IDX_W = $clog2(PAL_WORDS),
    localparam int ID_BASE   = (1 << IDX_W) - ID_WORDS
)(
    input  logic [IDX_W-1:0]     idx,
    output region_t              region,
    output logic [3:0]           reg_sel,
    output logic [PAL_IDX_W-1:0] pal_sel,
    output logic [2:0]           id_sel
);

    // Classify the index into one of the four regions
    always_comb begin
        region = RG_NONE;
        if (idx < IDX_W'(REG_WORDS))
            region = RG_REG;
        else if (idx >= IDX_W'(PAL_BASE) && idx < IDX_W'(PAL_BASE + PAL_WORDS))
            region = RG_PAL;
        else if (idx >= IDX_W'(ID_BASE))
            region = RG_ID;
    end

    // Local offsets within each region
    always_comb begin
        reg_sel = idx[3:0];
        pal_sel = PAL_IDX_W'(idx - IDX_W'(PAL_BASE));
        id_sel  = idx[2:0];
    end

endmodule

// File: rtl/lcdc_frame_timer.sv
// Module lcdc_frame_timer
// Down-counter that pulses tick once every PERIOD cycles while run is high.
// It holds at its reload value while run is low. A restart pulse reloads it
// and suppresses a tick in that cycle. Assumes PERIOD >= 1.
module lcdc_frame_timer #(
    parameter int PERIOD = 833_333,
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
)(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Expiry when running and the count has reached zero
    always_comb tick = run && (cnt_q == '0) && !restart;

    // Count down, reload on expiry, restart or stop
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= RELOAD;
        else if (restart || !run || cnt_q == '0)
            cnt_q <= RELOAD;
        else
            cnt_q <= cnt_q - 1'b1;
    end

endmodule

// File: rtl/lcdc_geometry.sv
// Module lcdc_geometry
// Derives panel size, pixel format flags and the display enable from the
// timing and control registers. Combinational. Assumes CTRL_W >= 12.
module lcdc_geometry
    import lcdc_regif_pkg::*;
#(
    parameter int CTRL_W = 16
)(
    input  logic [5:0]        ppl_field,
    input  logic [9:0]        lpp_field,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [DIM_W-1:0]  width,
    output logic [DIM_W-1:0]  height,
    output logic [2:0]        depth,
    output logic              swap,
    output logic              be_byte,
    output logic              be_pix,
    output logic              enable
);

    logic unused_ctrl;

    // Width is sixteen pixels per step of the field plus one step
    always_comb width = {({1'b0, ppl_field} + 7'd1), 4'b0000};

    // Height is the line field plus one
    always_comb height = {1'b0, lpp_field} + DIM_W'(1);

    // Format flags and the two-bit enable
    always_comb begin
        depth   = ctrl[3:1];
        swap    = ctrl[CB_SWAP];
        be_byte = ctrl[CB_BEBYTE];
        be_pix  = ctrl[CB_BEPIX];
        enable  = ctrl[CB_ENABLE] && ctrl[CB_POWER];
    end

    assign unused_ctrl = ^{ctrl[7:4], ctrl[CTRL_W-1:12]};

endmodule

// File: rtl/lcdc_palette.sv
// Module lcdc_palette
// Word-addressed palette store with one write port and one combinational
// read port. Every word is cleared by reset.
module lcdc_palette
    import lcdc_regif_pkg::*;
#(
    parameter int WORDS = 128,
    localparam int AW = $clog2(WORDS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Store one palette word when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (we && waddr == AW'(g))
                mem_q[g] <= wdata;
        end
    end

    // Read the addressed word
    always_comb rdata = mem_q[raddr];

endmodule

// File: rtl/lcdc_regif.sv
// Module lcdc_regif
// Register and interrupt unit of a colour LCD controller. It decodes bus
// accesses into timing, base, control, mask, status, palette and
// identification words, derives panel geometry and raises frame interrupts.
// Assumes at most one of bus_rd / bus_wr per cycle and a 32-bit bus.
module lcdc_regif
    import lcdc_regif_pkg::*;
#(
    parameter int VARIANT      = 0,
    parameter int FRAME_CYCLES = 833_333,
    parameter int ADDR_W       = 12,
    parameter int PAL_WORDS    = 128,
    parameter int ST_W         = 5,
    parameter int CTRL_W       = 16
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bad_acc,
    output logic              irq,
    output logic              disp_en,
    output logic [DIM_W-1:0]  act_width,
    output logic [DIM_W-1:0]  act_height,
    output logic [2:0]        pix_depth,
    output logic              rgb_swap,
    output logic              be_byte,
    output logic              be_pix,
    output logic [DATA_W-1:0] fb_upper,
    output logic [DATA_W-1:0] fb_lower
);

    localparam int IDX_W     = ADDR_W - 2;
    localparam int PAL_IDX_W = $clog2(PAL_WORDS);
    localparam int PAL_BASE  = 1 << (IDX_W - 3);
    localparam logic [3:0] IX_CTRL = (VARIANT == 0) ? 4'd6 : 4'd7;
    localparam logic [3:0] IX_MASK = (VARIANT == 0) ? 4'd7 : 4'd6;
    localparam logic [ST_W-1:0] FRAME_BITS =
        ST_W'((1 << SB_NEXTBASE) | (1 << SB_VCOMP));

    region_t              region;
    logic [3:0]           reg_sel;
    logic [PAL_IDX_W-1:0] pal_sel;
    logic [2:0]           id_sel;
    logic                 unused_lsb;

    logic [DATA_W-1:0]    timing_q [TIMING_WORDS];
    logic [DATA_W-1:0]    up_base_q;
    logic [DATA_W-1:0]    lo_base_q;
    logic [CTRL_W-1:0]    ctrl_q;
    logic [ST_W-1:0]      mask_q;
    logic [ST_W-1:0]      raw_q;
    logic [DATA_W-1:0]    rdata_q;
    logic                 bad_q;

    logic                 wr_reg;
    logic                 ctrl_wr;
    logic                 clr_wr;
    logic                 restart;
    logic                 tick;
    logic [DATA_W-1:0]    pal_rdata;
    logic [DATA_W-1:0]    rd_val;

    assign unused_lsb = ^bus_addr[1:0];

    lcdc_addr_decode #(
        .IDX_W     (IDX_W),
        .PAL_BASE  (PAL_BASE),
        .PAL_WORDS (PAL_WORDS)
    ) u_decode (
        .idx     (bus_addr[ADDR_W-1:2]),
        .region  (region),
        .reg_sel (reg_sel),
        .pal_sel (pal_sel),
        .id_sel  (id_sel)
    );

    // Write strobes for the register region
    always_comb begin
        wr_reg  = bus_wr && (region == RG_REG);
        ctrl_wr = wr_reg && (reg_sel == IX_CTRL);
        clr_wr  = wr_reg && (reg_sel == IX_CLEAR);
        restart = ctrl_wr && bus_wdata[CB_ENABLE] && bus_wdata[CB_POWER];
    end

    for (genvar g = 0; g < TIMING_WORDS; g++) begin : g_timing
        // Hold one timing word
        always_ff @(posedge clk) begin
            if (!rst_n)
                timing_q[g] <= '0;
            else if (wr_reg && reg_sel == 4'(g))
                timing_q[g] <= bus_wdata;
        end
    end

    // Frame base registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_base_q <= '0;
            lo_base_q <= '0;
        end else if (wr_reg) begin
            if (reg_sel == IX_UP_BASE) up_base_q <= bus_wdata;
            if (reg_sel == IX_LO_BASE) lo_base_q <= bus_wdata;
        end
    end

    // Control and mask registers at variant-dependent indices
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr_reg) begin
            if (reg_sel == IX_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (reg_sel == IX_MASK) mask_q <= bus_wdata[ST_W-1:0];
        end
    end

    // Raw status: clear by write-one, frame expiry sets and wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= '0;
        else
            raw_q <= (raw_q & ~(clr_wr ? bus_wdata[ST_W-1:0] : '0))
                   | (tick ? FRAME_BITS : '0);
    end

    lcdc_geometry #(
        .CTRL_W (CTRL_W)
    ) u_geom (
        .ppl_field (timing_q[0][7:2]),
        .lpp_field (timing_q[1][9:0]),
        .ctrl      (ctrl_q),
        .width     (act_width),
        .height    (act_height),
        .depth     (pix_depth),
        .swap      (rgb_swap),
        .be_byte   (be_byte),
        .be_pix    (be_pix),
        .enable    (disp_en)
    );

    lcdc_frame_timer #(
        .PERIOD (FRAME_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (disp_en),
        .restart (restart),
        .tick    (tick)
    );

    lcdc_palette #(
        .WORDS (PAL_WORDS)
    ) u_pal (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && region == RG_PAL),
        .waddr (pal_sel),
        .wdata (bus_wdata),
        .raddr (pal_sel),
        .rdata (pal_rdata)
    );

    // Select the value for the addressed word
    always_comb begin
        rd_val = '0;
        case (region)
            RG_REG: begin
                if (reg_sel < 4'(TIMING_WORDS))
                    rd_val = timing_q[reg_sel[1:0]];
                else if (reg_sel == IX_UP_BASE || reg_sel == IX_UP_CUR)
                    rd_val = up_base_q;
                else if (reg_sel == IX_LO_BASE || reg_sel == IX_LO_CUR)
                    rd_val = lo_base_q;
                else if (reg_sel == IX_CTRL)
                    rd_val = DATA_W'(ctrl_q);
                else if (reg_sel == IX_MASK)
                    rd_val = DATA_W'(mask_q);
                else if (reg_sel == IX_RAW)
                    rd_val = DATA_W'(raw_q);
                else if (reg_sel == IX_MASKED)
                    rd_val = DATA_W'(raw_q & mask_q);
            end
            RG_PAL:  rd_val = pal_rdata;
            RG_ID:   rd_val = DATA_W'(id_byte(VARIANT, id_sel));
            default: rd_val = '0;
        endcase
    end

    // Registered read data and the unmapped-access flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            bad_q   <= 1'b0;
        end else begin
            if (bus_rd) rdata_q <= rd_val;
            bad_q <= (bus_rd || bus_wr) && (region == RG_NONE);
        end
    end

    // Output assignments
    always_comb begin
        bus_rdata = rdata_q;
        bad_acc   = bad_q;
        irq       = |(raw_q & mask_q);
        fb_upper  = up_base_q;
        fb_lower  = lo_base_q;
    end

endmodule

// File: rtl/lcdc_regif_chk.sv
// Module lcdc_regif_chk
// Temporal checks on the LCD register unit, bound into every instance.
// Observes ports and a few internal handshakes between sub-blocks.
module lcdc_regif_chk #(
    parameter int ST_W = 5
)(
    input logic            clk,
    input logic            rst_n,
    input logic            bus_rd,
    input logic            bus_wr,
    input logic [31:0]     bus_wdata,
    input logic            bad_acc,
    input logic            irq,
    input logic            disp_en,
    input logic [10:0]     act_width,
    input logic [10:0]     act_height,
    input logic            tick,
    input logic            clr_wr,
    input logic [ST_W-1:0] raw,
    input logic [ST_W-1:0] mask
);

    assert_irq_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(tick) || ($past(mask) != mask)));

    assert_clear_drops_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && bus_wdata[2] && !tick) |=> !raw[2]);

    assert_dims_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(act_width) && $stable(act_height)));

    assert_enable_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(disp_en));

    assert_tick_only_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> disp_en);

    assert_tick_sets_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (raw[2] && raw[3]));

    assert_bad_follows_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |-> $past(bus_rd || bus_wr));

endmodule

bind lcdc_regif lcdc_regif_chk #(.ST_W(ST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bad_acc    (bad_acc),
    .irq        (irq),
    .disp_en    (disp_en),
    .act_width  (act_width),
    .act_height (act_height),
    .tick       (tick),
    .clr_wr     (clr_wr),
    .raw        (raw_q),
    .mask       (mask_q)
);

// File: tb/lcdc_regif_bench.sv
// Bench for lcdc_regif: a readback vector table, then directed tests.
// Inputs change on falling edges and outputs are sampled there.
module lcdc_regif_bench;

    localparam int CLK_PERIOD = 10;
    localparam int P          = 16;
    localparam int WDOG       = 20000;
    localparam int NVEC       = 17;

    // {requirement, byte offset, write data, expected readback}
    localparam logic [83:0] VEC [NVEC] = '{
        {8'd1,  12'h000, 32'h12345678, 32'h12345678},  // R1 timing0
        {8'd1,  12'h004, 32'hCAFE03FF, 32'hCAFE03FF},  // R1 timing1
        {8'd1,  12'h008, 32'hA5A5A5A5, 32'hA5A5A5A5},  // R1 timing2
        {8'd1,  12'h00C, 32'h0000BEEF, 32'h0000BEEF},  // R1 timing3
        {8'd1,  12'h010, 32'h80001000, 32'h80001000},  // R1 upper base
        {8'd1,  12'h014, 32'h80002000, 32'h80002000},  // R1 lower base
        {8'd1,  12'h02C, 32'hFFFFFFFF, 32'h80001000},  // R1 upper current ignores write
        {8'd1,  12'h030, 32'h00000000, 32'h80002000},  // R1 lower current ignores write
        {8'd2,  12'h01C, 32'hFFFFFFFF, 32'h0000001F},  // R2 mask at index 7
        {8'd2,  12'h018, 32'hFFFF0706, 32'h00000706},  // R2 control at index 6
        {8'd9,  12'h200, 32'hDEADBEEF, 32'hDEADBEEF},  // R9 first palette word
        {8'd9,  12'h3FC, 32'h01234567, 32'h01234567},  // R9 last palette word
        {8'd3,  12'h020, 32'hFFFFFFFF, 32'h00000000},  // R3 raw status read-only
        {8'd8,  12'hFE0, 32'hFFFFFFFF, 32'h00000010},  // R8 id word 0
        {8'd8,  12'hFFC, 32'h00000000, 32'h000000B1},  // R8 id word 7
        {8'd10, 12'h100, 32'h00000055, 32'h00000000},  // R10 unmapped
        {8'd10, 12'h034, 32'h00000077, 32'h00000000}   // R10 index 13
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_rd, bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;

    logic [31:0] rdata_b, rdata_e, fbu_b, fbl_b, fbu_e, fbl_e;
    logic        bad_b, bad_e, irq_b, irq_e, en_b, en_e;
    logic [10:0] wid_b, hgt_b, wid_e, hgt_e;
    logic [2:0]  dep_b, dep_e;
    logic        sw_b, bb_b, bp_b, sw_e, bb_e, bp_e;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdc_regif #(.VARIANT(0), .FRAME_CYCLES(P)) u_lcdc_regif (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .bad_acc(bad_b), .irq(irq_b), .disp_en(en_b), .act_width(wid_b),
        .act_height(hgt_b), .pix_depth(dep_b), .rgb_swap(sw_b),
        .be_byte(bb_b), .be_pix(bp_b), .fb_upper(fbu_b), .fb_lower(fbl_b)
    );

    lcdc_regif #(.VARIANT(2), .FRAME_CYCLES(P)) u_lcdc_regif_ext (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_e),
        .bad_acc(bad_e), .irq(irq_e), .disp_en(en_e), .act_width(wid_e),
        .act_height(hgt_e), .pix_depth(dep_e), .rgb_swap(sw_e),
        .be_byte(bb_e), .be_pix(bp_e), .fb_upper(fbu_e), .fb_lower(fbl_e)
    );

    task automatic chk(input int req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [11:0] a);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Watchdog: an expired run is a failure and still reports
    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk(11, rdata_b, 32'h0, "rdata after reset");
        chk(11, {31'b0, irq_b}, 32'h0, "irq after reset");
        chk(11, {31'b0, en_b}, 32'h0, "disp_en after reset");
        chk(11, {31'b0, bad_b}, 32'h0, "bad_acc after reset");
        chk(5, {21'b0, wid_b}, 32'd16, "width after reset");
        chk(5, {21'b0, hgt_b}, 32'd1, "height after reset");

        // Vector table: write, then read back
        for (int i = 0; i < NVEC; i++) begin
            bus_write(VEC[i][75:64], VEC[i][63:32]);
            bus_read(VEC[i][75:64]);
            chk(int'(VEC[i][83:76]), rdata_b, VEC[i][31:0], "table readback");
        end

        // R10 flag after unmapped read, cleared after idle, low for mapped
        bus_read(12'h400);
        chk(10, {31'b0, bad_b}, 32'h1, "bad_acc after unmapped read");
        chk(10, rdata_b, 32'h0, "unmapped read data");
        @(negedge clk);
        chk(10, {31'b0, bad_b}, 32'h0, "bad_acc one cycle only");
        bus_write(12'h040, 32'hFFFFFFFF);
        chk(10, {31'b0, bad_b}, 32'h1, "bad_acc after unmapped write");
        bus_read(12'h000);
        chk(10, {31'b0, bad_b}, 32'h0, "bad_acc after mapped read");
        chk(10, rdata_b, 32'h12345678, "timing0 untouched by unmapped writes");

        // R11 read data held while idle
        repeat (3) @(negedge clk);
        chk(11, rdata_b, 32'h12345678, "rdata held");

        // R5 geometry
        chk(5, {21'b0, wid_b}, 32'd496, "width from 0x78 field");
        chk(5, {21'b0, hgt_b}, 32'd1024, "height from 0x3FF field");
        bus_write(12'h000, 32'h00000003);
        chk(5, {21'b0, wid_b}, 32'd16, "width ignores bits 1:0");
        bus_write(12'h000, 32'h000000FF);
        chk(5, {21'b0, wid_b}, 32'd1024, "width max");
        bus_write(12'h004, 32'hFFFFFC00);
        chk(5, {21'b0, hgt_b}, 32'd1, "height min");

        // R6 flags from control 0x706
        chk(6, {29'b0, dep_b}, 32'd3, "depth");
        chk(6, {29'b0, sw_b, bb_b, bp_b}, 32'h7, "order flags");
        chk(6, {31'b0, en_b}, 32'h0, "no enable without bits 0 and 11");
        bus_write(12'h018, 32'h00000001);
        chk(6, {31'b0, en_b}, 32'h0, "enable bit alone");
        bus_write(12'h018, 32'h00000800);
        chk(6, {31'b0, en_b}, 32'h0, "power bit alone");

        // R7 / R4 frame expiry timing
        bus_write(12'h01C, 32'h0000000C);
        bus_write(12'h028, 32'h0000001F);
        bus_write(12'h018, 32'h00000801);
        chk(6, {31'b0, en_b}, 32'h1, "enable with both bits");
        repeat (P-1) @(negedge clk);
        chk(7, {31'b0, irq_b}, 32'h0, "no expiry before period");
        bus_write(12'h028, 32'h0000000C);
        chk(4, {31'b0, irq_b}, 32'h1, "expiry wins over same-cycle clear");
        bus_write(12'h028, 32'h0000000C);
        chk(4, {31'b0, irq_b}, 32'h0, "clear drops status");
        begin
            int n = 0;
            while (!irq_b && n < 4*P) begin
                @(negedge clk);
                n++;
            end
            chk(7, n, P-1, "second expiry spacing");
        end

        // R3 masked status and irq gating
        bus_write(12'h01C, 32'h00000004);
        bus_read(12'h024);
        chk(3, rdata_b, 32'h4, "masked status");
        bus_read(12'h020);
        chk(3, rdata_b, 32'hC, "raw status");
        chk(3, {31'b0, irq_b}, 32'h1, "irq with mask bit");
        bus_write(12'h01C, 32'h00000000);
        chk(3, {31'b0, irq_b}, 32'h0, "irq masked off");
        bus_read(12'h028);
        chk(4, rdata_b, 32'h0, "clear register reads zero");

        // R7 no expiries while disabled
        bus_write(12'h018, 32'h00000001);
        bus_write(12'h028, 32'h0000001F);
        bus_write(12'h01C, 32'h0000000C);
        repeat (3*P) @(negedge clk);
        chk(7, {31'b0, irq_b}, 32'h0, "no irq when disabled");
        bus_read(12'h020);
        chk(7, rdata_b, 32'h0, "raw status stays clear when disabled");

        // R2 / R8 other variant: control at 7, mask at 6, other id set
        bus_write(12'h01C, 32'h00000801);
        chk(2, {31'b0, en_e}, 32'h1, "variant 2 control at index 7");
        bus_write(12'h018, 32'h00000003);
        bus_read(12'h018);
        chk(2, rdata_e, 32'h3, "variant 2 mask at index 6");
        bus_read(12'hFE0);
        chk(8, rdata_e, 32'h11, "variant 2 id word 0");
        bus_read(12'hFE8);
        chk(8, rdata_e, 32'h24, "variant 2 id word 2");
        chk(8, rdata_b, 32'h04, "variant 0 id word 2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule